// File: doc/BRIEF.md
# Capture Compare PWM Timer

A single timer channel built around a 16-bit free-running up-counter. The counter advances either on ticks from a 7-bit programmable clock divider or, in pulse mode, on synchronised edges of an external pulse pin. Two channels sit beside the counter. Each one either latches the counter on an edge of its own pin (capture) or drives a pin when the counter steps onto a programmed value (compare).

A separate PWM generator shares the same tick. Its period and duty values are staged in shadow registers and only take effect when the PWM phase wraps. A flat register port sets up the block and reads it back. An overflow event and the two channel events raise sticky flags, and those flags can be routed to one interrupt line.

Top module: `ccp_timer`

## Requirements
- R1: After reset the counter, all flags, both compare pins, the PWM pin and the interrupt line are 0.
- R2: With CTRL[0]=1 and CTRL[1]=0, the counter rises by one every PSC+1 clock cycles (PSC at address 1, 7 bits). With CTRL[0]=0 it holds its value.
- R3: A write to address 10 loads the counter. A step from 0xFFFF to 0 sets FLAGS[0] (FLAGS at address 9).
- R4: With CTRL[1]=1, the counter steps once for each synchronised edge of pulse_in and PSC is ignored. CTRL[2]=0 selects rising edges and CTRL[2]=1 selects falling edges.
- R5: A channel in capture mode (CFGi[0]=0, CFGi at address 2+i) copies the counter into its capture register on the edge of cap_in[i] selected by CFGi[1] (0 rising, 1 falling), and sets FLAGS[1+i]. The capture register is read at address 4+i. The other edge is ignored.
- R6: A capture that arrives while FLAGS[1+i] is already set sets the overrun bit FLAGS[3+i]. The capture register then holds the newest value.
- R7: A channel in compare mode (CFGi[0]=1) acts on cmp_out[i] in the cycle the counter steps onto the value written at address 4+i, and it sets FLAGS[1+i]. CFGi[3:2] selects the action: 1 set, 2 clear, 3 toggle, 0 none. At no other time does cmp_out[i] change.
- R8: Writing 1 to a FLAGS bit clears that bit, and writing 0 leaves it unchanged. If a new event and a clear fall in the same cycle, the event wins.
- R9: irq is high exactly when some flag is set whose enable bit is set at address 8. Bit 0 enables overflow and bit 1+i enables channel i. Overrun bits never drive irq.
- R10: The PWM phase counts ticks from 0 to the active period and then wraps, so one cycle lasts period+1 ticks. pwm_out is high while the phase is below the active duty.
- R11: Writes to PERIOD (address 6) and DUTY (address 7) reach only the shadow registers. The active values load from the shadows only when the PWM phase wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cap_in | input | 2 | Capture pins, one per channel |
| pulse_in | input | 1 | External pulse source for pulse mode |
| cmp_out | output | 2 | Compare pins, one per channel |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. The counter, the compare pins and the PWM pin then move at the same edge as the tick that causes the change. A pin edge on cap_in or pulse_in only acts at the third edge after the change, because it passes two synchroniser stages and then an edge detector. The bench therefore waits four cycles after each pin change before it looks at the result. The counter runs only inside windows whose length in edges is known exactly, and it is stopped before anything is read back. Every compare and PWM outcome can then be derived from the edge count. The one exception is the duty measurement, which counts high cycles over a window of whole PWM periods, so where the window starts does not matter.

// File: rtl/ccp_timer_pkg.sv
package ccp_timer_pkg;

  localparam int CCP_NCH = 2;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_PSC  = 4'd1;
  localparam logic [3:0] A_CFG0 = 4'd2;
  localparam logic [3:0] A_CFG1 = 4'd3;
  localparam logic [3:0] A_VAL0 = 4'd4;
  localparam logic [3:0] A_VAL1 = 4'd5;
  localparam logic [3:0] A_PER  = 4'd6;
  localparam logic [3:0] A_DUTY = 4'd7;
  localparam logic [3:0] A_IEN  = 4'd8;
  localparam logic [3:0] A_FLAG = 4'd9;
  localparam logic [3:0] A_CNT  = 4'd10;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } cmp_act_e;

  typedef struct packed {
    cmp_act_e act;      // [3:2]
    logic     cap_fall; // [1]
    logic     is_cmp;   // [0]
  } chan_cfg_t;

  // Edge detector on a synchronised level against its previous sample.
  function automatic logic edge_seen(input logic now, input logic prev, input logic fall);
    return fall ? (prev & ~now) : (now & ~prev);
  endfunction

  // Level of a compare pin after a match.
  function automatic logic apply_act(input logic cur, input cmp_act_e act);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/ccp_tick_gen.sv
module ccp_tick_gen
  import ccp_timer_pkg::*;
#(
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse_mode,
  input  logic             pulse_fall,
  input  logic [PSC_W-1:0] psc,
  input  logic             pulse_in,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;
  logic [2:0]       ps_q;   // [0] first stage, [1] second stage, [2] previous
  logic             div_hit;
  logic             pulse_edge;

  assign div_hit    = (div_q >= psc);
  assign pulse_edge = edge_seen(ps_q[1], ps_q[2], pulse_fall);
  assign tick       = run & (pulse_mode ? pulse_edge : div_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      div_q <= '0;
    end else begin
      ps_q <= {ps_q[1:0], pulse_in};
      if (!run || pulse_mode || div_hit) div_q <= '0;
      else                               div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/ccp_chan.sv
module ccp_chan
  import ccp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt,
  output logic             cmp_hit,
  output logic             cmp_out
);

  logic [2:0]       cs_q;   // [0] first stage, [1] second stage, [2] previous
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;
  assign cap_evt = ~cfg.is_cmp & edge_seen(cs_q[1], cs_q[2], cfg.cap_fall);
  assign cmp_hit = cfg.is_cmp & step & (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      cap_val <= '0;
      cmp_out <= 1'b0;
    end else begin
      cs_q <= {cs_q[1:0], cap_in};
      if (cap_evt) cap_val <= cnt;
      if (cmp_hit) cmp_out <= apply_act(cmp_out, cfg.act);
    end
  end

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_sh,
  input  logic [CNT_W-1:0] duty_sh,
  output logic             wrap,
  output logic [CNT_W-1:0] duty_act,
  output logic             pwm_out
);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] per_act;

  assign wrap    = tick & (phase_q >= per_act);
  assign pwm_out = (phase_q < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (wrap) begin
      phase_q  <= '0;
      per_act  <= per_sh;
      duty_act <= duty_sh;
    end else if (tick) begin
      phase_q  <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/ccp_timer.sv
module ccp_timer
  import ccp_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 7,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  input  logic [CCP_NCH-1:0]   cap_in,
  input  logic                 pulse_in,
  output logic [CCP_NCH-1:0]   cmp_out,
  output logic                 pwm_out,
  output logic                 irq
);

  localparam int FLAG_W = 1 + 2 * CCP_NCH;

  logic [2:0]         ctrl_q;   // [0] run, [1] pulse mode, [2] pulse falling edge
  logic [PSC_W-1:0]   psc_q;
  chan_cfg_t          cfg_q   [CCP_NCH];
  logic [CNT_W-1:0]   cmp_q   [CCP_NCH];
  logic [CNT_W-1:0]   per_q;
  logic [CNT_W-1:0]   duty_q;
  logic [CCP_NCH:0]   ien_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;
  logic [CCP_NCH-1:0] ev_q;
  logic [CCP_NCH-1:0] ovr_q;

  // Named internal events, also observed by the checker.
  logic               tick_w;
  logic               cnt_load_w;
  logic               step_w;
  logic               wrap_evt_w;
  logic [CCP_NCH-1:0] cap_evt_w;
  logic [CCP_NCH-1:0] cmp_hit_w;
  logic [CNT_W-1:0]   cap_val_w [CCP_NCH];
  logic [FLAG_W-1:0]  flags_w;
  logic [FLAG_W-1:0]  clr_w;
  logic               pwm_wrap_w;
  logic [CNT_W-1:0]   duty_act_w;

  function automatic logic wr_at(input logic en, input logic [ADDR_W-1:0] a,
                                 input logic [3:0] target);
    return en && (a == ADDR_W'(target));
  endfunction

  assign cnt_load_w = wr_at(wr_en, wr_addr, A_CNT);
  assign step_w     = tick_w & ~cnt_load_w;
  assign wrap_evt_w = step_w & (cnt_q == '1);
  assign clr_w      = wr_at(wr_en, wr_addr, A_FLAG) ? wr_data[FLAG_W-1:0] : '0;
  assign flags_w    = {ovr_q, ev_q, ovf_q};
  assign irq        = |({ev_q, ovf_q} & ien_q);

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      ien_q  <= '0;
      for (int i = 0; i < CCP_NCH; i++) begin
        cfg_q[i] <= '0;
        cmp_q[i] <= '0;
      end
    end else begin
      if (wr_at(wr_en, wr_addr, A_CTRL)) ctrl_q <= wr_data[2:0];
      if (wr_at(wr_en, wr_addr, A_PSC))  psc_q  <= wr_data[PSC_W-1:0];
      if (wr_at(wr_en, wr_addr, A_PER))  per_q  <= wr_data;
      if (wr_at(wr_en, wr_addr, A_DUTY)) duty_q <= wr_data;
      if (wr_at(wr_en, wr_addr, A_IEN))  ien_q  <= wr_data[CCP_NCH:0];
      for (int i = 0; i < CCP_NCH; i++) begin
        if (wr_at(wr_en, wr_addr, A_CFG0 + 4'(i))) cfg_q[i] <= chan_cfg_t'(wr_data[3:0]);
        if (wr_at(wr_en, wr_addr, A_VAL0 + 4'(i))) cmp_q[i] <= wr_data;
      end
    end
  end

  // Main counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_load_w) cnt_q <= wr_data;
    else if (tick_w)     cnt_q <= cnt_q + 1'b1;
  end

  // Sticky flags, set has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ev_q  <= '0;
      ovr_q <= '0;
    end else begin
      ovf_q <= wrap_evt_w | (ovf_q & ~clr_w[0]);
      ev_q  <= cap_evt_w | cmp_hit_w | (ev_q & ~clr_w[CCP_NCH:1]);
      ovr_q <= (cap_evt_w & ev_q) | (ovr_q & ~clr_w[FLAG_W-1:CCP_NCH+1]);
    end
  end

  ccp_tick_gen #(.PSC_W(PSC_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q[0]),
    .pulse_mode (ctrl_q[1]),
    .pulse_fall (ctrl_q[2]),
    .psc        (psc_q),
    .pulse_in   (pulse_in),
    .tick       (tick_w)
  );

  for (genvar g = 0; g < CCP_NCH; g++) begin : g_chan
    ccp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q[g]),
      .cap_in  (cap_in[g]),
      .cnt     (cnt_q),
      .step    (step_w),
      .cmp_val (cmp_q[g]),
      .cap_val (cap_val_w[g]),
      .cap_evt (cap_evt_w[g]),
      .cmp_hit (cmp_hit_w[g]),
      .cmp_out (cmp_out[g])
    );
  end

  ccp_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .per_sh   (per_q),
    .duty_sh  (duty_q),
    .wrap     (pwm_wrap_w),
    .duty_act (duty_act_w),
    .pwm_out  (pwm_out)
  );

  // Read mux
  always_comb begin
    rd_data = '0;
    case (4'(rd_addr))
      A_CTRL: rd_data[2:0]        = ctrl_q;
      A_PSC:  rd_data[PSC_W-1:0]  = psc_q;
      A_CFG0: rd_data[3:0]        = cfg_q[0];
      A_CFG1: rd_data[3:0]        = cfg_q[1];
      A_VAL0: rd_data             = cap_val_w[0];
      A_VAL1: rd_data             = cap_val_w[1];
      A_PER:  rd_data             = per_q;
      A_DUTY: rd_data             = duty_q;
      A_IEN:  rd_data[CCP_NCH:0]  = ien_q;
      A_FLAG: rd_data[FLAG_W-1:0] = flags_w;
      A_CNT:  rd_data             = cnt_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ccp_timer_sva.sv
module ccp_timer_sva
  import ccp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               cnt_load,
  input logic [CNT_W-1:0]   cnt,
  input logic               ovf,
  input logic [CCP_NCH-1:0] ev,
  input logic [CCP_NCH-1:0] cap_evt,
  input logic [CCP_NCH-1:0] cmp_hit,
  input logic [CCP_NCH-1:0] cmp_out,
  input logic               irq,
  input logic               pwm_wrap,
  input logic [CNT_W-1:0]   duty_act
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load) |=> $stable(cnt));

  a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && (cnt == '1)) |=> ovf);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ({ev, ovf} != '0));

  a_r11_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_wrap |=> $stable(duty_act));

  for (genvar i = 0; i < CCP_NCH; i++) begin : g_ch
    a_r5_event_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> ev[i]);
    a_r7_cmp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_hit[i] |=> $stable(cmp_out[i]));
  end

endmodule

bind ccp_timer ccp_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_w),
  .cnt_load (cnt_load_w),
  .cnt      (cnt_q),
  .ovf      (ovf_q),
  .ev       (ev_q),
  .cap_evt  (cap_evt_w),
  .cmp_hit  (cmp_hit_w),
  .cmp_out  (cmp_out),
  .irq      (irq),
  .pwm_wrap (pwm_wrap_w),
  .duty_act (duty_act_w)
);

// File: tb/ccp_timer_test.sv
module ccp_timer_test;

  localparam int CLK_PER = 10;

  localparam logic [3:0] T_CTRL = 4'd0, T_PSC = 4'd1, T_CFG0 = 4'd2, T_CFG1 = 4'd3,
                         T_VAL0 = 4'd4, T_VAL1 = 4'd5, T_PER = 4'd6, T_DUTY = 4'd7,
                         T_IEN = 4'd8, T_FLAG = 4'd9, T_CNT = 4'd10;

  localparam int K_REG = 0, K_PIN = 1, K_VAL = 2;
  localparam int P_CMP0 = 0, P_CMP1 = 1, P_PWM = 2, P_IRQ = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cap_in = '0;
  logic        pulse_in = 1'b0;
  logic [1:0]  cmp_out;
  logic        pwm_out;
  logic        irq;

  typedef struct packed {
    logic [7:0]  kind;
    logic [7:0]  addr;
    logic [31:0] exp;
    logic [31:0] got;
  } item_t;

  item_t sb_q[$];
  string req_q[$];
  int    n_chk  = 0;
  int    n_err  = 0;
  int    n_push = 0;
  int    n_done = 0;
  bit    finished = 1'b0;

  ccp_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pulse_in(pulse_in),
    .cmp_out(cmp_out), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  // Monitor: pops expected items and compares them with what the design shows.
  initial begin
    forever begin
      item_t it;
      string rq;
      int    got;
      wait (sb_q.size() != 0);
      #1;
      it = sb_q.pop_front();
      rq = req_q.pop_front();
      got = 0;
      case (int'(it.kind))
        K_REG: begin rd_addr = it.addr[3:0]; #1; got = int'(rd_data); end
        K_PIN: begin
          case (int'(it.addr))
            P_CMP0:  got = int'(cmp_out[0]);
            P_CMP1:  got = int'(cmp_out[1]);
            P_PWM:   got = int'(pwm_out);
            default: got = int'(irq);
          endcase
        end
        default: got = int'(it.got);
      endcase
      n_chk++;
      if (got != int'(it.exp)) begin
        n_err++;
        $display("FAIL %s: actual %0h expected %0h", rq, got, it.exp);
      end
      n_done++;
    end
  end

  task automatic push_item(input string rq, input int kind, input int a, input int e, input int g);
    item_t it;
    it.kind = 8'(kind); it.addr = 8'(a); it.exp = 32'(e); it.got = 32'(g);
    sb_q.push_back(it);
    req_q.push_back(rq);
    n_push++;
    wait (n_done == n_push);
    @(negedge clk);
  endtask

  task automatic chk_reg(input string rq, input logic [3:0] a, input int e);
    push_item(rq, K_REG, int'(a), e, 0);
  endtask

  task automatic chk_pin(input string rq, input int p, input int e);
    push_item(rq, K_PIN, p, e, 0);
  endtask

  task automatic chk_val(input string rq, input int g, input int e);
    push_item(rq, K_VAL, 0, e, g);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counter runs for m+1 clock edges in the given mode, then stops.
  task automatic run_for(input int m, input logic [2:0] mode);
    wr(T_CTRL, {13'd0, mode | 3'b001});
    repeat (m) @(negedge clk);
    wr(T_CTRL, {13'd0, mode & 3'b110});
  endtask

  task automatic pin_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_high(input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg("R1 counter", T_CNT, 0);
    chk_reg("R1 flags", T_FLAG, 0);
    chk_pin("R1 cmp_out0", P_CMP0, 0);
    chk_pin("R1 pwm_out", P_PWM, 0);
    chk_pin("R1 irq", P_IRQ, 0);

    // R2 prescaler divide by 4: ten edges give two ticks
    wr(T_PSC, 16'd3);
    run_for(9, 3'b000);
    chk_reg("R2 divide by 4", T_CNT, 2);
    chk_reg("R2 hold while stopped", T_CNT, 2);
    wr(T_PSC, 16'd0);
    run_for(4, 3'b000);
    chk_reg("R2 divide by 1", T_CNT, 7);

    // R3 load and overflow, R9 irq, R8 clear
    wr(T_CNT, 16'hFFFE);
    chk_reg("R3 load", T_CNT, 16'hFFFE);
    wr(T_IEN, 16'h0001);
    chk_pin("R9 irq idle", P_IRQ, 0);
    run_for(2, 3'b000);
    chk_reg("R3 wrapped count", T_CNT, 1);
    chk_reg("R3 overflow flag", T_FLAG, 1);
    chk_pin("R9 irq on overflow", P_IRQ, 1);
    wr(T_FLAG, 16'h0000);
    chk_reg("R8 write zero keeps flag", T_FLAG, 1);
    wr(T_FLAG, 16'h0001);
    chk_reg("R8 cleared", T_FLAG, 0);
    chk_pin("R9 irq released", P_IRQ, 0);

    // R4 pulse mode, prescaler ignored
    wr(T_PSC, 16'd5);
    wr(T_CNT, 16'd0);
    wr(T_CTRL, 16'h0003);
    for (int k = 0; k < 3; k++) begin
      pulse_in = 1'b1; pin_wait(3);
      pulse_in = 1'b0; pin_wait(3);
    end
    pin_wait(4);
    wr(T_CTRL, 16'h0002);
    chk_reg("R4 rising pulses", T_CNT, 3);
    wr(T_CNT, 16'd0);
    wr(T_CTRL, 16'h0007);
    for (int k = 0; k < 2; k++) begin
      pulse_in = 1'b1; pin_wait(3);
      pulse_in = 1'b0; pin_wait(3);
    end
    pin_wait(4);
    wr(T_CTRL, 16'h0000);
    chk_reg("R4 falling pulses", T_CNT, 2);
    wr(T_PSC, 16'd0);

    // R5 capture
    wr(T_CFG0, 16'h0000);
    wr(T_CFG1, 16'h0002);
    wr(T_CNT, 16'h1234);
    cap_in[0] = 1'b1; pin_wait(4);
    chk_reg("R5 capture value ch0", T_VAL0, 16'h1234);
    chk_reg("R5 flag ch0", T_FLAG, 2);
    cap_in[1] = 1'b1; pin_wait(4);
    chk_reg("R5 rising ignored ch1", T_FLAG, 2);
    wr(T_CNT, 16'h0055);
    cap_in[1] = 1'b0; pin_wait(4);
    chk_reg("R5 capture value ch1", T_VAL1, 16'h0055);
    chk_reg("R5 flag ch1", T_FLAG, 6);

    // R6 overrun on ch0
    cap_in[0] = 1'b0; pin_wait(4);
    wr(T_CNT, 16'h0777);
    cap_in[0] = 1'b1; pin_wait(4);
    chk_reg("R6 newest capture", T_VAL0, 16'h0777);
    chk_reg("R6 overrun bit", T_FLAG, 16'h000E);
    wr(T_IEN, 16'h0001);
    chk_pin("R9 masked channel flags", P_IRQ, 0);
    wr(T_IEN, 16'h0004);
    chk_pin("R9 ch1 enabled", P_IRQ, 1);
    wr(T_FLAG, 16'h001F);
    chk_reg("R8 clear all", T_FLAG, 0);
    chk_pin("R9 irq low after clear", P_IRQ, 0);

    // R7 compare
    wr(T_CFG0, 16'h000D);
    wr(T_VAL0, 16'd5);
    wr(T_CFG1, 16'h0005);
    wr(T_VAL1, 16'd7);
    wr(T_CNT, 16'd0);
    run_for(9, 3'b000);
    chk_reg("R7 count", T_CNT, 10);
    chk_pin("R7 toggle ch0", P_CMP0, 1);
    chk_pin("R7 set ch1", P_CMP1, 1);
    chk_reg("R7 flags", T_FLAG, 6);
    wr(T_FLAG, 16'h001F);
    wr(T_CFG1, 16'h0009);
    wr(T_VAL1, 16'd12);
    wr(T_VAL0, 16'd100);
    run_for(4, 3'b000);
    chk_pin("R7 clear ch1", P_CMP1, 0);
    chk_pin("R7 no match keeps ch0", P_CMP0, 1);
    chk_reg("R7 only ch1 flag", T_FLAG, 4);
    wr(T_FLAG, 16'h001F);

    // R11 shadowed period and duty
    wr(T_PER, 16'd3);
    wr(T_DUTY, 16'd2);
    chk_pin("R11 shadow not applied", P_PWM, 0);
    run_for(0, 3'b000);
    chk_pin("R11 loaded at wrap", P_PWM, 1);
    wr(T_DUTY, 16'd0);
    chk_pin("R11 duty write buffered", P_PWM, 1);
    run_for(0, 3'b000);
    chk_pin("R10 phase 1 below duty", P_PWM, 1);
    run_for(0, 3'b000);
    chk_pin("R10 phase 2 at duty", P_PWM, 0);
    run_for(0, 3'b000);
    run_for(0, 3'b000);
    chk_pin("R11 new duty after wrap", P_PWM, 0);

    // R10 duty over whole periods
    wr(T_DUTY, 16'd1);
    wr(T_CTRL, 16'h0001);
    pin_wait(12);
    measure_high(40, hi);
    chk_val("R10 duty 1 of 4", hi, 10);
    wr(T_DUTY, 16'd3);
    pin_wait(12);
    measure_high(40, hi);
    chk_val("R10 duty 3 of 4", hi, 30);
    wr(T_PER, 16'd7);
    wr(T_DUTY, 16'd2);
    pin_wait(20);
    measure_high(40, hi);
    chk_val("R10 duty 2 of 8", hi, 10);
    wr(T_CTRL, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule